// File: doc/BRIEF.md
# Edge-Interrupt Parallel I/O Port

This peripheral gives a processor four 8-bit general-purpose ports behind a small byte-wide register bus. Every pin has its own output latch and its own direction bit. The pad level can be read back through a two-flop synchronizer. The pad drivers appear at the edge of the block as three separate vectors: input level, output value and output enable.

The first two ports also carry per-pin interrupt logic. Each pin has an edge select that picks no edge, rising, falling or both edges. Each pin has a sticky flag that software clears by writing a one to it, and an enable that lets the flag reach the port's own request line. Each of the two ports therefore raises its own interrupt. The remaining ports have no interrupt registers: those offsets read as zero and ignore writes.

Each port owns a block of eight byte addresses. The upper address bits select the port and the lower three bits select the register.

Top module: `gpio_edge_port`

## Requirements
- R1: After a synchronous reset, pad_out, pad_oe, irq and bus_rdata are all zero.
- R2: A write to offset 1 of a port sets that port's byte of pad_out, and a write to offset 2 sets its byte of pad_oe (1 = drive). Both registers read back with the written value.
- R3: Offset 0 returns the pad level of the port two clock edges after it is sampled. Writes to offset 0 change nothing.
- R4: Read data appears on bus_rdata at the first clock edge after a read request, and holds until the next read request.
- R5: The edge select is 2 bits per pin: 00 off, 01 rising, 10 falling, 11 both. Offset 4 holds pins 0 to 3 and offset 5 holds pins 4 to 7, with pin i using bits 2i+1:2i of its byte. A pin with select 00 never sets its flag.
- R6: Offset 6 holds the sticky flags. A flag stays set until a 1 is written to its bit. Writing 0 to a bit leaves it unchanged.
- R7: irq[p] is high when any flag of port p is set and its enable bit (offset 3) is set. Flags are set even when the enable is clear. When a pad edge is enabled, irq rises four clock edges after the pad change.
- R8: Ports 2 and 3 read 0 at offsets 3 to 6, ignore writes there, and never raise a request.
- R9: When an edge sets a flag in the same cycle that software clears it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Port index (upper bits) and register offset (lower 3 bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 32 | Pad input levels, port p on bits 8p+7:8p |
| pad_out | output | 32 | Output latch values |
| pad_oe | output | 32 | Output enables |
| irq | output | 2 | Interrupt request of port 0 and port 1 |

## Verification
A pad change made between clock edges has a fixed latency:
- It becomes readable at offset 0 after two edges.
- It sets a flag on the third edge.
- It raises irq on the fourth edge.

A register read returns its data one edge after the request. A register write drives pad_out or pad_oe on the edge that takes it. The bench drives every input at a falling edge and counts whole cycles up to the due edge before it samples. For interrupt timing it checks that irq is still low after three edges and high after the fourth. The set-wins case is built by placing the clearing write on exactly the edge that records the flag.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register offsets inside one port's eight-address block
  typedef enum logic [2:0] {
    OFS_IN      = 3'd0,
    OFS_OUT     = 3'd1,
    OFS_DIR     = 3'd2,
    OFS_IEN     = 3'd3,
    OFS_ESEL_LO = 3'd4,
    OFS_ESEL_HI = 3'd5,
    OFS_FLAG    = 3'd6,
    OFS_RSVD    = 3'd7
  } reg_ofs_e;

  // Per-pin edge select code
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_in;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   level,
  input  logic [2*PINS-1:0] esel,
  output logic [PINS-1:0]   hit
);

  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic       rise_w, fall_w;
    edge_mode_e mode_w;

    assign rise_w = level[i] & ~prev_q[i];
    assign fall_w = ~level[i] & prev_q[i];
    assign mode_w = edge_mode_e'(esel[2*i +: 2]);

    always_comb begin
      unique case (mode_w)
        EDGE_RISE: hit[i] = rise_w;
        EDGE_FALL: hit[i] = fall_w;
        EDGE_BOTH: hit[i] = rise_w | fall_w;
        default:   hit[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int unsigned PINS    = 8,
  parameter bit          HAS_IRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_ofs_e          wr_ofs,
  input  logic [PINS-1:0]   wr_data,
  input  logic [PINS-1:0]   pad_sync,
  output logic [PINS-1:0]   out_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   ien_q,
  output logic [2*PINS-1:0] esel_q,
  output logic [PINS-1:0]   flag_q,
  output logic              irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      if (wr_ofs == OFS_OUT) out_q <= wr_data;
      if (wr_ofs == OFS_DIR) dir_q <= wr_data;
    end
  end

  if (HAS_IRQ) begin : g_irq
    logic [PINS-1:0] hit_w;
    logic [PINS-1:0] clr_w;
    logic            flag_wr_w;

    gpio_edge_detect #(.PINS(PINS)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .level (pad_sync),
      .esel  (esel_q),
      .hit   (hit_w)
    );

    assign flag_wr_w = wr_en && (wr_ofs == OFS_FLAG);
    assign clr_w     = flag_wr_w ? wr_data : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        ien_q  <= '0;
        esel_q <= '0;
        flag_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        if (wr_en && wr_ofs == OFS_IEN)     ien_q <= wr_data;
        if (wr_en && wr_ofs == OFS_ESEL_LO) esel_q[PINS-1:0] <= wr_data;
        if (wr_en && wr_ofs == OFS_ESEL_HI) esel_q[2*PINS-1:PINS] <= wr_data;
        // a new edge outranks a clear in the same cycle
        flag_q <= (flag_q & ~clr_w) | hit_w;
        irq_q  <= |(flag_q & ien_q);
      end
    end

    // R6: without a flag write, no flag bit may drop
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      !flag_wr_w |=> (($past(flag_q) & ~flag_q) == '0));

    // R5: with every select at 00, no flag bit may rise
    a_r5_off_no_flag: assert property (@(posedge clk) disable iff (rst)
      (esel_q == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

  end else begin : g_no_irq
    assign ien_q  = '0;
    assign esel_q = '0;
    assign flag_q = '0;
    assign irq_q  = 1'b0;
  end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPORTS    = 4,
  parameter int unsigned PINS      = 8,
  parameter int unsigned IRQ_PORTS = 2,
  localparam int unsigned PIDX_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int unsigned ADDR_W   = PIDX_W + 3,
  localparam int unsigned NPINS    = NPORTS * PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [IRQ_PORTS-1:0] irq
);

  logic [NPINS-1:0]  pad_sync;
  logic [PIDX_W-1:0] port_idx;
  reg_ofs_e          reg_ofs;

  logic [PINS-1:0]   out_a  [NPORTS];
  logic [PINS-1:0]   dir_a  [NPORTS];
  logic [PINS-1:0]   ien_a  [NPORTS];
  logic [2*PINS-1:0] esel_a [NPORTS];
  logic [PINS-1:0]   flag_a [NPORTS];
  logic              irq_a  [NPORTS];
  logic [PINS-1:0]   rd_next;

  assign port_idx = bus_addr[ADDR_W-1:3];
  assign reg_ofs  = reg_ofs_e'(bus_addr[2:0]);

  gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpio_port_bank #(
      .PINS    (PINS),
      .HAS_IRQ (p < IRQ_PORTS)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_sel && bus_we && (int'(port_idx) == p)),
      .wr_ofs   (reg_ofs),
      .wr_data  (bus_wdata),
      .pad_sync (pad_sync[p*PINS +: PINS]),
      .out_q    (out_a[p]),
      .dir_q    (dir_a[p]),
      .ien_q    (ien_a[p]),
      .esel_q   (esel_a[p]),
      .flag_q   (flag_a[p]),
      .irq_q    (irq_a[p])
    );
    assign pad_out[p*PINS +: PINS] = out_a[p];
    assign pad_oe[p*PINS +: PINS]  = dir_a[p];
  end

  for (genvar q = 0; q < IRQ_PORTS; q++) begin : g_irq_out
    assign irq[q] = irq_a[q];
  end

  always_comb begin
    rd_next = '0;
    if (int'(port_idx) < NPORTS) begin
      unique case (reg_ofs)
        OFS_IN:      rd_next = pad_sync[int'(port_idx)*PINS +: PINS];
        OFS_OUT:     rd_next = out_a[port_idx];
        OFS_DIR:     rd_next = dir_a[port_idx];
        OFS_IEN:     rd_next = ien_a[port_idx];
        OFS_ESEL_LO: rd_next = esel_a[port_idx][PINS-1:0];
        OFS_ESEL_HI: rd_next = esel_a[port_idx][2*PINS-1:PINS];
        OFS_FLAG:    rd_next = flag_a[port_idx];
        default:     rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_next;
  end

  // R2: pad drive only changes on a bus write
  a_r2_pads_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_we) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R4: read data holds between read requests
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset;
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {30'd0, irq}, 0);
    chk("R1 rdata", {24'd0, bus_rdata}, 0);
  endtask

  task automatic t_outputs;
    logic [7:0] d;
    wr(5'd9, 8'hA5);
    wr(5'd10, 8'h3C);
    wr(5'd25, 8'h81);
    chk("R2 port1 out", {24'd0, pad_out[15:8]}, 32'hA5);
    chk("R2 port1 oe", {24'd0, pad_oe[15:8]}, 32'h3C);
    chk("R2 port3 out", {24'd0, pad_out[31:24]}, 32'h81);
    rd(5'd9, d);
    chk("R4 read out", {24'd0, d}, 32'hA5);
    idle(2);
    chk("R4 rdata held", {24'd0, bus_rdata}, 32'hA5);
    rd(5'd10, d);
    chk("R2 read dir", {24'd0, d}, 32'h3C);
  endtask

  task automatic t_input;
    logic [7:0] d;
    pad_in[23:16] = 8'h5A;
    idle(2);
    rd(5'd16, d);
    chk("R3 input", {24'd0, d}, 32'h5A);
    wr(5'd16, 8'hFF);
    rd(5'd16, d);
    chk("R3 input write ignored", {24'd0, d}, 32'h5A);
    pad_in[23:16] = 8'h00;
    idle(3);
  endtask

  task automatic t_rising;
    logic [7:0] d;
    wr(5'd4, 8'h01);
    wr(5'd3, 8'h01);
    pad_in[0] = 1'b1;
    idle(3);
    chk("R7 irq not early", {31'd0, irq[0]}, 0);
    idle(1);
    chk("R7 irq on fourth edge", {31'd0, irq[0]}, 1);
    pad_in[0] = 1'b0;
    idle(4);
    rd(5'd6, d);
    chk("R5 rising only", {24'd0, d}, 32'h01);
    wr(5'd6, 8'h00);
    rd(5'd6, d);
    chk("R6 write 0 keeps", {24'd0, d}, 32'h01);
    wr(5'd6, 8'h01);
    rd(5'd6, d);
    chk("R6 write 1 clears", {24'd0, d}, 32'h00);
    idle(1);
    chk("R7 irq drops", {31'd0, irq[0]}, 0);
  endtask

  task automatic t_modes;
    logic [7:0] d;
    wr(5'd12, 8'h38);
    wr(5'd13, 8'h01);
    pad_in[12:9] = 4'hF;
    idle(4);
    rd(5'd14, d);
    chk("R5 rise codes", {24'd0, d}, 32'h14);
    chk("R7 no irq when disabled", {31'd0, irq[1]}, 0);
    wr(5'd14, 8'hFF);
    pad_in[12:9] = 4'h0;
    idle(4);
    rd(5'd14, d);
    chk("R5 fall codes", {24'd0, d}, 32'h06);
    wr(5'd11, 8'h02);
    idle(1);
    chk("R7 irq after enable", {31'd0, irq[1]}, 1);
    wr(5'd11, 8'h00);
    wr(5'd14, 8'hFF);
  endtask

  task automatic t_noirq;
    logic [7:0] d;
    wr(5'd19, 8'hFF);
    wr(5'd20, 8'hFF);
    wr(5'd21, 8'hFF);
    pad_in[23:16] = 8'hFF;
    idle(4);
    rd(5'd22, d);
    chk("R8 port2 flag", {24'd0, d}, 0);
    rd(5'd19, d);
    chk("R8 port2 enable", {24'd0, d}, 0);
    rd(5'd20, d);
    chk("R8 port2 select", {24'd0, d}, 0);
    chk("R8 irq quiet", {30'd0, irq}, 0);
  endtask

  task automatic t_setwins;
    logic [7:0] d;
    wr(5'd4, 8'h04);
    pad_in[1] = 1'b1;
    idle(4);
    pad_in[1] = 1'b0;
    idle(4);
    pad_in[1] = 1'b1;
    idle(2);
    wr(5'd6, 8'h02);
    rd(5'd6, d);
    chk("R9 set beats clear", {24'd0, d}, 32'h02);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_outputs();
    t_input();
    t_rising();
    t_modes();
    t_noirq();
    t_setwins();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule